// File: doc/BRIEF.md
# Remote Sensing Frame Admission Filter

This block sits in the central controller of a distributed DC-bus leakage monitor. Remote measurement nodes deliver decoded frames, one per `in_valid` strobe. Each frame holds a node number, an 8-bit sequence count, a 16-bit acquisition time, a payload of measurement bytes, a byte of local self-test flags and a 16-bit check code. The block decides in a single step whether each frame is passed on or dropped.

A frame is passed on only if three tests succeed, in this order. The check code must match. The sequence count must move forward for that node. The acquisition time must lie close enough to the controller's reference time. Frames that pass are forwarded with a one-cycle valid strobe. A frame that fails is counted against the first test it failed.

The block also keeps a millisecond liveness timer per node. A node that has delivered no accepted frame for too long is marked unavailable. When too many nodes are unavailable, a degraded flag tells the downstream ranking logic to suspend fine-grained fault location.

Top module: `frame_guard`

## Requirements
- R1: The check code is a CRC-16 with polynomial 0x1021 and start value 0xFFFF, each byte fed most significant bit first. It covers these bytes in order: the node number zero-extended to a byte, the sequence count, the time high byte, the time low byte, the payload bytes starting from its most significant byte, and the status byte. A frame whose `in_crc` differs is dropped and `rej_crc_cnt` rises by one.
- R2: Sequence rule. The first frame a node sends after reset is accepted whatever its count. After that, a frame passes only if (count − last accepted count) mod 256 lies in 1..127. Otherwise it is dropped and `rej_seq_cnt` rises by one. This test runs only on frames whose check code matched.
- R3: When a frame is accepted with a modular step d greater than 1, `lost_cnt` rises by d−1, saturating at its all-ones value.
- R4: The time test applies to frames that passed R1 and R2. The difference `in_ts − ref_time`, read as a signed 16-bit value, must have magnitude ≤ `cfg_window`. If it does not, the frame is dropped and `rej_align_cnt` rises by one.
- R5: An accepted frame raises `out_valid` for exactly one cycle, in the cycle after `in_valid`. That cycle carries the frame's node, time, payload and status. Dropped frames produce no `out_valid`.
- R6: The three reject counters saturate at all-ones (255 by default) and never decrease.
- R7: After reset every node is unavailable. A node becomes available in the cycle after one of its frames is accepted, and that acceptance restarts its timer.
- R8: On each cycle with `tick_ms` high, each available node's timer advances by one, unless that node has a frame accepted in the same cycle. The node becomes unavailable on the tick that brings its timer to `cfg_timeout`.
- R9: `degraded` resets to 1. It is set one cycle after the number of unavailable nodes is ≥ `cfg_limit`. It is cleared one cycle after that number is 0. In all other cases it holds its value.
- R10: A dropped frame changes neither the sending node's availability nor its stored sequence count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame present this cycle |
| in_node | input | ID_W | Sending node number |
| in_seq | input | 8 | Sequence count |
| in_ts | input | 16 | Acquisition time |
| in_payload | input | PAY_BYTES*8 | Measurement bytes |
| in_status | input | 8 | Node self-test flags |
| in_crc | input | 16 | Received check code |
| ref_time | input | 16 | Controller reference time |
| cfg_window | input | 16 | Allowed time distance |
| tick_ms | input | 1 | Millisecond tick strobe |
| cfg_timeout | input | TMO_W | Silence limit in ticks |
| cfg_limit | input | $clog2(2**ID_W+1) | Unavailable-node count that sets degraded |
| out_valid | output | 1 | Accepted frame strobe |
| out_node | output | ID_W | Accepted node number |
| out_ts | output | 16 | Accepted acquisition time |
| out_payload | output | PAY_BYTES*8 | Accepted payload |
| out_status | output | 8 | Accepted self-test flags |
| rej_crc_cnt | output | CNT_W | Check-code rejects |
| rej_seq_cnt | output | CNT_W | Sequence rejects |
| rej_align_cnt | output | CNT_W | Time-window rejects |
| lost_cnt | output | LOST_W | Frames missing from accepted gaps |
| node_avail | output | 2**ID_W | Per-node availability |
| degraded | output | 1 | Too many nodes silent |

## Verification
The in-module properties are checked on every cycle. They cover these points: an output strobe always follows an input frame, and a check-code mismatch never yields one. Counters never move backwards. Any accepted frame revives its node, while an unavailable node stays down without an acceptance. The degraded flag holds while any node is unavailable.

Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model:
- the exact arithmetic of sequence wrap and the 127/128 boundary,
- the lost-frame sum,
- time differences that cross the 16-bit wrap,
- the tick on which a timer expires,
- the case where a tick and an acceptance arrive together,
- counter saturation.

// File: rtl/fg_pkg.sv
package fg_pkg;
   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;
   localparam int SEQ_W = 8;
   localparam int TS_W  = 16;

   typedef enum logic [1:0] {
      V_PASS  = 2'd0,
      V_CRC   = 2'd1,
      V_SEQ   = 2'd2,
      V_ALIGN = 2'd3
   } verdict_e;

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) begin
         r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/fg_crc16.sv
module fg_crc16 #(
   parameter int NBYTES = 9
) (
   input  logic [NBYTES*8-1:0] data,
   output logic [15:0]         crc
);
   import fg_pkg::*;

   logic [15:0] chain [0:NBYTES];
   assign chain[0] = CRC_SEED;

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      assign chain[k+1] = crc_byte(chain[k], data[(NBYTES-1-k)*8 +: 8]);
   end

   assign crc = chain[NBYTES];
endmodule

// File: rtl/fg_sat_cnt.sv
module fg_sat_cnt #(
   parameter int W  = 8,
   parameter int AW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] amount,
   output logic [W-1:0]  cnt
);
   if (AW > W) begin : g_bad_width
      $error("fg_sat_cnt: AW must not exceed W");
   end

   logic [W:0] sum;
   assign sum = {1'b0, cnt} + (W+1)'(amount);

   always_ff @(posedge clk) begin
      if (!rst_n)  cnt <= '0;
      else if (en) cnt <= sum[W] ? {W{1'b1}} : sum[W-1:0];
   end

   assert_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt) <= cnt);
endmodule

// File: rtl/fg_seq_track.sv
module fg_seq_track #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] q_node,
   input  logic [7:0]      q_seq,
   input  logic            upd,
   output logic            seq_ok,
   output logic [7:0]      step
);
   localparam int NODES = 1 << ID_W;

   logic [7:0]       last [NODES];
   logic [NODES-1:0] seen;
   logic [7:0]       diff;

   always_comb begin
      diff   = q_seq - last[q_node];
      seq_ok = !seen[q_node] || (diff != 8'd0 && !diff[7]);
      step   = seen[q_node] ? diff : 8'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
         for (int n = 0; n < NODES; n++) last[n] <= '0;
      end else if (upd) begin
         seen[q_node] <= 1'b1;
         last[q_node] <= q_seq;
      end
   end

   assert_accept_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> seq_ok);
endmodule

// File: rtl/fg_liveness.sv
module fg_liveness #(
   parameter int ID_W  = 4,
   parameter int TMO_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            acc,
   input  logic [ID_W-1:0]                 acc_node,
   input  logic                            tick,
   input  logic [TMO_W-1:0]                cfg_timeout,
   input  logic [$clog2((1<<ID_W)+1)-1:0]  cfg_limit,
   output logic [(1<<ID_W)-1:0]            avail,
   output logic                            degraded
);
   localparam int NODES = 1 << ID_W;
   localparam int CW    = $clog2(NODES + 1);

   for (genvar n = 0; n < NODES; n++) begin : g_node
      logic [TMO_W-1:0] tmr;
      logic             av;
      logic             hit;
      assign hit = acc && (acc_node == ID_W'(n));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tmr <= '0;
            av  <= 1'b0;
         end else if (hit) begin
            tmr <= '0;
            av  <= 1'b1;
         end else if (tick && av) begin
            tmr <= tmr + 1'b1;
            if (({1'b0, tmr} + 1'b1) >= {1'b0, cfg_timeout}) av <= 1'b0;
         end
      end

      assign avail[n] = av;

      assert_stay_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!av && !hit) |=> !av);
   end

   logic [CW-1:0] down_cnt;
   assign down_cnt = CW'($countones(~avail));

   always_ff @(posedge clk) begin
      if (!rst_n)                      degraded <= 1'b1;
      else if (down_cnt >= cfg_limit)  degraded <= 1'b1;
      else if (down_cnt == '0)         degraded <= 1'b0;
   end

   assert_revive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> avail[$past(acc_node)]);
   assert_degraded_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (degraded && down_cnt != '0) |=> degraded);
endmodule

// File: rtl/frame_guard.sv
module frame_guard #(
   parameter int ID_W      = 4,
   parameter int PAY_BYTES = 4,
   parameter int CNT_W     = 8,
   parameter int LOST_W    = 16,
   parameter int TMO_W     = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [ID_W-1:0]                 in_node,
   input  logic [7:0]                      in_seq,
   input  logic [15:0]                     in_ts,
   input  logic [PAY_BYTES*8-1:0]          in_payload,
   input  logic [7:0]                      in_status,
   input  logic [15:0]                     in_crc,
   input  logic [15:0]                     ref_time,
   input  logic [15:0]                     cfg_window,
   input  logic                            tick_ms,
   input  logic [TMO_W-1:0]                cfg_timeout,
   input  logic [$clog2((1<<ID_W)+1)-1:0]  cfg_limit,
   output logic                            out_valid,
   output logic [ID_W-1:0]                 out_node,
   output logic [15:0]                     out_ts,
   output logic [PAY_BYTES*8-1:0]          out_payload,
   output logic [7:0]                      out_status,
   output logic [CNT_W-1:0]                rej_crc_cnt,
   output logic [CNT_W-1:0]                rej_seq_cnt,
   output logic [CNT_W-1:0]                rej_align_cnt,
   output logic [LOST_W-1:0]               lost_cnt,
   output logic [(1<<ID_W)-1:0]            node_avail,
   output logic                            degraded
);
   import fg_pkg::*;

   localparam int PAY_W  = PAY_BYTES * 8;
   localparam int NBYTES = PAY_BYTES + 5;

   if (ID_W < 1 || ID_W > 7) begin : g_bad_id
      $error("frame_guard: ID_W out of range");
   end
   if (PAY_BYTES < 1) begin : g_bad_pay
      $error("frame_guard: PAY_BYTES must be at least 1");
   end
   if (LOST_W < 8 || CNT_W < 1) begin : g_bad_cnt
      $error("frame_guard: counter widths too small");
   end

   // ---- check code over the serialised frame
   logic [15:0] crc_calc;
   fg_crc16 #(.NBYTES(NBYTES)) u_crc (
      .data ({8'(in_node), in_seq, in_ts, in_payload, in_status}),
      .crc  (crc_calc)
   );

   // ---- sequence tracking
   logic       seq_ok;
   logic [7:0] step;
   logic       acc;
   fg_seq_track #(.ID_W(ID_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .q_node (in_node),
      .q_seq  (in_seq),
      .upd    (acc),
      .seq_ok (seq_ok),
      .step   (step)
   );

   // ---- time alignment
   logic [15:0] tdiff, tmag;
   logic        align_ok;
   always_comb begin
      tdiff    = in_ts - ref_time;
      tmag     = tdiff[15] ? (~tdiff + 16'd1) : tdiff;
      align_ok = tmag <= cfg_window;
   end

   // ---- combined verdict, first failing test wins
   verdict_e verdict;
   always_comb begin
      if (crc_calc != in_crc) verdict = V_CRC;
      else if (!seq_ok)       verdict = V_SEQ;
      else if (!align_ok)     verdict = V_ALIGN;
      else                    verdict = V_PASS;
   end
   assign acc = in_valid && (verdict == V_PASS);

   // ---- reject counters, one per reason
   logic [CNT_W-1:0] rej_cnt [3];
   for (genvar r = 0; r < 3; r++) begin : g_rej
      fg_sat_cnt #(.W(CNT_W), .AW(1)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (in_valid && (verdict == verdict_e'(2'(r + 1)))),
         .amount (1'b1),
         .cnt    (rej_cnt[r])
      );
   end
   assign rej_crc_cnt   = rej_cnt[0];
   assign rej_seq_cnt   = rej_cnt[1];
   assign rej_align_cnt = rej_cnt[2];

   fg_sat_cnt #(.W(LOST_W), .AW(8)) u_lost (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (acc && step > 8'd1),
      .amount (step - 8'd1),
      .cnt    (lost_cnt)
   );

   // ---- liveness and degraded mode
   fg_liveness #(.ID_W(ID_W), .TMO_W(TMO_W)) u_live (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .acc_node    (in_node),
      .tick        (tick_ms),
      .cfg_timeout (cfg_timeout),
      .cfg_limit   (cfg_limit),
      .avail       (node_avail),
      .degraded    (degraded)
   );

   // ---- forwarded sample
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_node    <= '0;
         out_ts      <= '0;
         out_payload <= '0;
         out_status  <= '0;
      end else begin
         out_valid <= acc;
         if (acc) begin
            out_node    <= in_node;
            out_ts      <= in_ts;
            out_payload <= in_payload;
            out_status  <= in_status;
         end
      end
   end

   assert_out_follows_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   assert_bad_code_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_crc != crc_calc) |=> !out_valid);
   assert_drop_counts_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones({rej_crc_cnt != $past(rej_crc_cnt),
                                rej_seq_cnt != $past(rej_seq_cnt),
                                rej_align_cnt != $past(rej_align_cnt), out_valid}) <= 1));
endmodule

// File: tb/frame_guard_test.sv
module frame_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_node = '0;
   logic [7:0]  in_seq = '0;
   logic [15:0] in_ts = '0;
   logic [31:0] in_payload = '0;
   logic [7:0]  in_status = '0;
   logic [15:0] in_crc = '0;
   logic [15:0] ref_time = 16'd1000;
   logic [15:0] cfg_window = 16'd100;
   logic        tick_ms = 1'b0;
   logic [15:0] cfg_timeout = 16'd5;
   logic [4:0]  cfg_limit = 5'd3;
   logic        out_valid;
   logic [3:0]  out_node;
   logic [15:0] out_ts;
   logic [31:0] out_payload;
   logic [7:0]  out_status;
   logic [7:0]  rej_crc_cnt, rej_seq_cnt, rej_align_cnt;
   logic [15:0] lost_cnt;
   logic [15:0] node_avail;
   logic        degraded;

   always #5ns clk = ~clk;

   frame_guard uut (.*);

   int total = 0;
   int bad = 0;
   bit done = 0;

   // ---------------- reference model
   bit [7:0]  m_last [16];
   bit        m_seen [16];
   bit        m_av   [16];
   int        m_tmr  [16];
   int        m_crc, m_seq, m_align, m_lost;
   bit        m_deg, m_ov;
   bit [3:0]  m_node;
   bit [15:0] m_ts;
   bit [31:0] m_pay;
   bit [7:0]  m_stat;

   function automatic logic [15:0] ref_crc(input logic [3:0] n, input logic [7:0] s,
                                           input logic [15:0] t, input logic [31:0] p,
                                           input logic [7:0] st);
      logic [7:0]  bytes [9];
      logic [15:0] c;
      bytes = '{{4'h0, n}, s, t[15:8], t[7:0], p[31:24], p[23:16], p[15:8], p[7:0], st};
      c = 16'hFFFF;
      for (int i = 0; i < 9; i++) begin
         for (int k = 7; k >= 0; k--) begin
            logic fb;
            fb = c[15] ^ bytes[i][k];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 16; n++) begin
            m_last[n] = 0; m_seen[n] = 0; m_av[n] = 0; m_tmr[n] = 0;
         end
         m_crc = 0; m_seq = 0; m_align = 0; m_lost = 0; m_deg = 1; m_ov = 0;
      end else begin
         int down;
         int hit;
         down = 0;
         hit  = -1;
         for (int n = 0; n < 16; n++) if (!m_av[n]) down++;
         if (down >= int'(cfg_limit)) m_deg = 1;
         else if (down == 0)          m_deg = 0;
         m_ov = 0;
         if (in_valid) begin
            int d, td;
            d  = (int'(in_seq) - int'(m_last[in_node])) & 255;
            td = int'(in_ts) - int'(ref_time);
            if (td > 32767)  td -= 65536;
            if (td < -32768) td += 65536;
            if (td < 0) td = -td;
            if (ref_crc(in_node, in_seq, in_ts, in_payload, in_status) != in_crc)
               m_crc = (m_crc < 255) ? m_crc + 1 : 255;
            else if (m_seen[in_node] && (d == 0 || d >= 128))
               m_seq = (m_seq < 255) ? m_seq + 1 : 255;
            else if (td > int'(cfg_window))
               m_align = (m_align < 255) ? m_align + 1 : 255;
            else begin
               if (m_seen[in_node] && d > 1) m_lost = (m_lost + d - 1 > 65535) ? 65535 : m_lost + d - 1;
               m_seen[in_node] = 1;
               m_last[in_node] = in_seq;
               m_ov = 1; m_node = in_node; m_ts = in_ts; m_pay = in_payload; m_stat = in_status;
               hit = int'(in_node);
            end
         end
         for (int n = 0; n < 16; n++) begin
            if (n == hit) begin
               m_av[n] = 1; m_tmr[n] = 0;
            end else if (tick_ms && m_av[n]) begin
               m_tmr[n]++;
               if (m_tmr[n] >= int'(cfg_timeout)) m_av[n] = 0;
            end
         end
      end
   end

   // ---------------- checking helpers
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [15:0] av;
      for (int n = 0; n < 16; n++) av[n] = m_av[n];
      chk("R5 out_valid", 64'(out_valid), 64'(m_ov));
      if (m_ov && out_valid) begin
         chk("R5 out_node", 64'(out_node), 64'(m_node));
         chk("R5 out_ts", 64'(out_ts), 64'(m_ts));
         chk("R5 out_payload", 64'(out_payload), 64'(m_pay));
         chk("R5 out_status", 64'(out_status), 64'(m_stat));
      end
      chk("R1 rej_crc_cnt", 64'(rej_crc_cnt), 64'(m_crc));
      chk("R2 rej_seq_cnt", 64'(rej_seq_cnt), 64'(m_seq));
      chk("R4 rej_align_cnt", 64'(rej_align_cnt), 64'(m_align));
      chk("R3 lost_cnt", 64'(lost_cnt), 64'(m_lost));
      chk("R7 R8 node_avail", 64'(node_avail), 64'(av));
      chk("R9 degraded", 64'(degraded), 64'(m_deg));
   endtask

   task automatic cyc();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic send(input logic [3:0] n, input logic [7:0] s, input logic [15:0] t,
                       input bit corrupt, input bit with_tick = 0);
      in_valid   = 1'b1;
      in_node    = n;
      in_seq     = s;
      in_ts      = t;
      in_payload = {s, 4'h0, n, t};
      in_status  = {n, 4'hA};
      in_crc     = ref_crc(n, s, t, in_payload, in_status) ^ (corrupt ? 16'h0001 : 16'h0000);
      tick_ms    = with_tick;
      cyc();
      in_valid   = 1'b0;
      tick_ms    = 1'b0;
   endtask

   task automatic tick();
      tick_ms = 1'b1;
      cyc();
      tick_ms = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      // reset state, R7 and R9
      chk("R7 reset avail", 64'(node_avail), 64'h0);
      chk("R9 reset degraded", 64'(degraded), 64'h1);
      chk("R5 reset out_valid", 64'(out_valid), 64'h0);

      // first frame from every node, any count accepted (R2), revive (R7)
      for (int n = 0; n < 16; n++) send(4'(n), 8'd10, 16'd1000, 0);
      cyc(); cyc();
      chk("R9 cleared with all up", 64'(degraded), 64'h0);

      // sequence rules R2 / R3 on node 3
      send(4'd3, 8'd11, 16'd1000, 0);
      send(4'd3, 8'd11, 16'd1000, 0);   // repeat
      send(4'd3, 8'd9, 16'd1000, 0);    // backwards
      send(4'd3, 8'd14, 16'd1000, 0);   // gap of 3, two lost
      send(4'd3, 8'd142, 16'd1000, 0);  // step 128 rejected
      send(4'd3, 8'd141, 16'd1000, 0);  // step 127 accepted
      // wrap on node 4
      send(4'd4, 8'd100, 16'd1000, 0);
      send(4'd4, 8'd200, 16'd1000, 0);
      send(4'd4, 8'd250, 16'd1000, 0);
      send(4'd4, 8'd3, 16'd1000, 0);

      // check code R1, and a drop leaves the sequence untouched (R10)
      send(4'd2, 8'd11, 16'd1000, 1);
      send(4'd2, 8'd11, 16'd1000, 0);

      // time window R4
      send(4'd6, 8'd11, 16'd1101, 0);
      send(4'd6, 8'd11, 16'd1100, 0);
      send(4'd6, 8'd12, 16'd899, 0);
      send(4'd6, 8'd12, 16'd900, 0);
      ref_time = 16'd10;
      send(4'd6, 8'd13, 16'd65500, 0);  // -46 across wrap
      send(4'd6, 8'd14, 16'd65000, 0);  // -546 rejected
      ref_time = 16'd1000;

      // timeouts R8, with acceptance and tick together on node 0
      tick(); tick(); tick(); tick();
      send(4'd0, 8'(m_last[0] + 1), 16'd1000, 0, 1);
      tick();
      cyc();
      chk("R8 others expired", 64'(node_avail), 64'h0001);
      chk("R9 degraded set", 64'(degraded), 64'h1);

      // drop to an unavailable node keeps it down (R10)
      send(4'd5, m_last[5], 16'd1000, 0);
      cyc();
      chk("R10 node5 still down", 64'(node_avail[5]), 64'h0);

      // partial recovery keeps degraded (R9), full recovery clears
      for (int n = 1; n < 15; n++) send(4'(n), 8'(m_last[n] + 1), 16'd1000, 0);
      cyc(); cyc();
      chk("R9 held with one down", 64'(degraded), 64'h1);
      send(4'd15, 8'(m_last[15] + 1), 16'd1000, 0);
      cyc(); cyc();
      chk("R9 cleared after recovery", 64'(degraded), 64'h0);

      // saturation R6
      for (int i = 0; i < 260; i++) send(4'd7, 8'd50, 16'd1000, 1);
      cyc();
      chk("R6 crc counter saturated", 64'(rej_crc_cnt), 64'd255);

      cyc();
      finish_up();
   end
endmodule